// File: doc/BRIEF.md
# Software Store/Recall Sequence Detector

This block watches the access stream of an SRAM port in which each chip-enable-controlled access is presented as one event, and recognises a fixed unlock pattern of six consecutive reads. The first five reads must hit a fixed chain of addresses. The address of the sixth read then picks the operation: one value requests a copy of the SRAM into the nonvolatile shadow (store) and another requests the reverse copy (recall). The result is a single-cycle request pulse to the transfer sequencer.

The reads that make up the pattern still complete as ordinary reads elsewhere, so this block carries no data. It only tracks how far the pattern has got. Any write, or any read that does not match, abandons the pattern. While the transfer sequencer reports busy, the detector holds itself at idle and disregards every access. A store-inhibit level blocks store requests, which happens for example during low supply. Recall requests are never blocked by it.

The access strobe works like a valid signal that has no ready. Every strobed cycle is taken in the cycle it appears, and the block never applies back-pressure. All other pins are plain levels.

Top module: `nvs_seq_detect`

## Requirements
- R1: After reset, the detector is idle and neither `store_req` nor `recall_req` is high.
- R2: Six consecutive strobed reads are 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F. In the cycle after the clock edge that takes the sixth read, `store_req` is high for exactly one cycle.
- R3: The same five-read prefix followed by a read of 0x0F0E raises `recall_req` for exactly one cycle, with the same timing.
- R4: A strobed access with `acc_write`=1 (a write), at any address and at any step, returns the detector to idle. No request follows from that sequence.
- R5: A strobed read whose address is not the expected next one returns the detector to idle. A sixth address other than 0x0F0F or 0x0F0E counts as such a mismatch.
- R6: A mismatching read at address 0x0000 is not discarded. It counts as the first step of a new sequence, so the next read expected is 0x1555.
- R7: Cycles with `acc_valid`=0 do not advance or abort the sequence. Only strobed accesses count, and there is no output-enable input.
- R8: While `store_inhibit`=1, a completed store sequence gives no `store_req`, and the detector still returns to idle. A completed recall sequence still gives `recall_req`.
- R9: While `xfer_busy`=1, no request is raised and the detector is forced to idle. Accesses strobed during that time count as no step.
- R10: After a request pulse, the detector is idle, so a further request needs all six reads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle strobe, one per chip-enable-controlled access |
| acc_addr | input | 13 | Address of the strobed access |
| acc_write | input | 1 | 1 = the strobed access is a write, 0 = a read |
| xfer_busy | input | 1 | Transfer sequencer busy; the detector idles and ignores accesses |
| store_inhibit | input | 1 | Blocks store requests; recall is unaffected |
| store_req | output | 1 | One-cycle store request pulse |
| recall_req | output | 1 | One-cycle recall request pulse |

## Verification
Every result comes out of one register stage. A request caused by the access taken at clock edge k is high only between edges k and k+1. The bench drives each access on a falling edge and samples the outputs on the next falling edge, which falls inside that one-cycle window. It samples again one falling edge later to confirm that the pulse has already ended. Abort, busy and inhibit cases are judged by finishing the rest of a pattern afterwards and checking at the same sample point that no pulse appears.

// File: rtl/nvs_seq_pkg.sv
package nvs_seq_pkg;
  localparam int KEY_W      = 13;
  localparam int PREFIX_LEN = 5;
  localparam logic [KEY_W-1:0] STORE_KEY  = 13'h0F0F;
  localparam logic [KEY_W-1:0] RECALL_KEY = 13'h0F0E;

  // Ordered prefix of the unlock pattern; the order is behaviour.
  function automatic logic [KEY_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 13'h0000;
      1:       prefix_key = 13'h1555;
      2:       prefix_key = 13'h0AAA;
      3:       prefix_key = 13'h1FFF;
      default: prefix_key = 13'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/nvs_key_match.sv
module nvs_key_match #(
  parameter int ADDR_W = nvs_seq_pkg::KEY_W,
  parameter int NPRE   = nvs_seq_pkg::PREFIX_LEN,
  localparam int STEP_W = $clog2(NPRE + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] step,
  output logic              prefix_hit,
  output logic              is_first,
  output logic              is_store,
  output logic              is_recall
);
  logic [NPRE-1:0] hit_vec;

  for (genvar g = 0; g < NPRE; g++) begin : g_key
    assign hit_vec[g] = (addr == ADDR_W'(nvs_seq_pkg::prefix_key(g)));
  end

  always_comb begin
    prefix_hit = 1'b0;
    for (int i = 0; i < NPRE; i++)
      if (step == STEP_W'(i)) prefix_hit = hit_vec[i];
  end

  assign is_first  = hit_vec[0];
  assign is_store  = (addr == ADDR_W'(nvs_seq_pkg::STORE_KEY));
  assign is_recall = (addr == ADDR_W'(nvs_seq_pkg::RECALL_KEY));
endmodule

// File: rtl/nvs_step_tracker.sv
module nvs_step_tracker #(
  parameter int NPRE = nvs_seq_pkg::PREFIX_LEN,
  localparam int STEP_W = $clog2(NPRE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              is_wr,
  input  logic              busy,
  input  logic              inhibit,
  input  logic              prefix_hit,
  input  logic              is_first,
  input  logic              is_store,
  input  logic              is_recall,
  output logic [STEP_W-1:0] step,
  output logic              store_req,
  output logic              recall_req
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NPRE);

  logic [STEP_W-1:0] restart;
  assign restart = is_first ? STEP_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      if (busy) begin
        step <= '0;
      end else if (take) begin
        if (is_wr) begin
          step <= '0;
        end else if (step == LAST) begin
          if (is_store || is_recall) begin
            store_req  <= is_store & ~inhibit;
            recall_req <= is_recall;
            step       <= '0;
          end else begin
            step <= restart;
          end
        end else if (prefix_hit) begin
          step <= step + 1'b1;
        end else begin
          step <= restart;
        end
      end
    end
  end

  // R10: the step counter never runs past the final step
  a_r10_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);
  // R10: a request always leaves the tracker idle
  a_r10_idle_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> step == '0);
endmodule

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect #(
  parameter int ADDR_W = nvs_seq_pkg::KEY_W,
  parameter int NPRE   = nvs_seq_pkg::PREFIX_LEN,
  localparam int STEP_W = $clog2(NPRE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              xfer_busy,
  input  logic              store_inhibit,
  output logic              store_req,
  output logic              recall_req
);
  logic [STEP_W-1:0] step;
  logic prefix_hit, is_first, is_store, is_recall;

  nvs_key_match #(.ADDR_W(ADDR_W), .NPRE(NPRE)) u_match (
    .addr(acc_addr), .step(step), .prefix_hit(prefix_hit),
    .is_first(is_first), .is_store(is_store), .is_recall(is_recall)
  );

  nvs_step_tracker #(.NPRE(NPRE)) u_track (
    .clk(clk), .rst_n(rst_n), .take(acc_valid), .is_wr(acc_write),
    .busy(xfer_busy), .inhibit(store_inhibit), .prefix_hit(prefix_hit),
    .is_first(is_first), .is_store(is_store), .is_recall(is_recall),
    .step(step), .store_req(store_req), .recall_req(recall_req)
  );

  // R2/R3: never both requests at once
  a_r3_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_req, recall_req}));
  // R2: store pulse lasts one cycle
  a_r2_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  // R3: recall pulse lasts one cycle
  a_r3_recall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  // R4: a write never produces a request
  a_r4_write_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> !store_req && !recall_req);
  // R7: no strobe, no request
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !store_req && !recall_req);
  // R8: inhibit blocks store
  a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    store_inhibit |=> !store_req);
  // R9: busy blocks every request
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> !store_req && !recall_req);
endmodule

// File: tb/test_nvs_seq_detect.sv
module test_nvs_seq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, xfer_busy = 1'b0, store_inhibit = 1'b0;
  logic [12:0] acc_addr = '0;
  logic store_req, recall_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nvs_seq_detect i_nvs_seq_detect (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .xfer_busy(xfer_busy), .store_inhibit(store_inhibit),
    .store_req(store_req), .recall_req(recall_req)
  );

  logic [12:0] pre [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual {store,recall}=%b expected %b", req, act, exp);
    end
  endtask

  // One strobed access; returns outputs seen in the cycle after its edge.
  task automatic acc(input logic [12:0] a, input logic wr, output logic [1:0] seen);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    seen = {store_req, recall_req};
  endtask

  task automatic prefix(input int from);
    logic [1:0] s;
    for (int i = from; i < 5; i++) acc(pre[i], 1'b0, s);
  endtask

  task automatic t_reset;
    chk("R1 reset", {store_req, recall_req}, 2'b00);
    @(negedge clk);
    chk("R1 reset idle", {store_req, recall_req}, 2'b00);
  endtask

  task automatic t_store;
    logic [1:0] s;
    prefix(0); acc(13'h0F0F, 1'b0, s);
    chk("R2 store pulse", s, 2'b10);
    @(negedge clk);
    chk("R2 store one cycle", {store_req, recall_req}, 2'b00);
  endtask

  task automatic t_recall;
    logic [1:0] s;
    prefix(0); acc(13'h0F0E, 1'b0, s);
    chk("R3 recall pulse", s, 2'b01);
    @(negedge clk);
    chk("R3 recall one cycle", {store_req, recall_req}, 2'b00);
  endtask

  task automatic t_write_abort;
    logic [1:0] s;
    prefix(0); acc(13'h0000, 1'b1, s);
    acc(13'h0F0F, 1'b0, s);
    chk("R4 write before last", s, 2'b00);
    acc(13'h0000, 1'b0, s); acc(13'h1555, 1'b0, s); acc(13'h0AAA, 1'b1, s);
    prefix(3); acc(13'h0F0E, 1'b0, s);
    chk("R4 write mid-prefix", s, 2'b00);
    prefix(0); acc(13'h0F0F, 1'b1, s);
    chk("R4 write at sixth key", s, 2'b00);
  endtask

  task automatic t_wrong;
    logic [1:0] s;
    acc(13'h0000, 1'b0, s); acc(13'h1555, 1'b0, s); acc(13'h0123, 1'b0, s);
    prefix(2); acc(13'h0F0F, 1'b0, s);
    chk("R5 wrong read aborts", s, 2'b00);
    prefix(0); acc(13'h0F0D, 1'b0, s);
    acc(13'h0F0F, 1'b0, s);
    chk("R5 bad sixth key", s, 2'b00);
  endtask

  task automatic t_restart;
    logic [1:0] s;
    acc(13'h0000, 1'b0, s); acc(13'h1555, 1'b0, s); acc(13'h0AAA, 1'b0, s);
    acc(13'h0000, 1'b0, s);
    prefix(1); acc(13'h0F0F, 1'b0, s);
    chk("R6 restart at 0x0000", s, 2'b10);
    prefix(0); acc(13'h0000, 1'b0, s);
    prefix(1); acc(13'h0F0E, 1'b0, s);
    chk("R6 restart from step 6", s, 2'b01);
  endtask

  task automatic t_gaps;
    logic [1:0] s;
    for (int i = 0; i < 5; i++) begin
      acc(pre[i], 1'b0, s);
      repeat (3) @(negedge clk);
    end
    acc(13'h0F0F, 1'b0, s);
    chk("R7 idle gaps", s, 2'b10);
  endtask

  task automatic t_inhibit;
    logic [1:0] s;
    store_inhibit = 1'b1;
    prefix(0); acc(13'h0F0F, 1'b0, s);
    chk("R8 inhibit store", s, 2'b00);
    acc(13'h0F0E, 1'b0, s);
    chk("R8 inhibit back to idle", s, 2'b00);
    prefix(0); acc(13'h0F0E, 1'b0, s);
    chk("R8 recall under inhibit", s, 2'b01);
    store_inhibit = 1'b0;
  endtask

  task automatic t_busy;
    logic [1:0] s;
    acc(13'h0000, 1'b0, s); acc(13'h1555, 1'b0, s);
    xfer_busy = 1'b1;
    acc(13'h0AAA, 1'b0, s);
    xfer_busy = 1'b0;
    prefix(3); acc(13'h0F0F, 1'b0, s);
    chk("R9 busy resets", s, 2'b00);
    prefix(0);
    xfer_busy = 1'b1;
    acc(13'h0F0F, 1'b0, s);
    chk("R9 busy blocks", s, 2'b00);
    xfer_busy = 1'b0;
    acc(13'h0F0F, 1'b0, s);
    chk("R9 ignored access", s, 2'b00);
  endtask

  task automatic t_after;
    logic [1:0] s;
    prefix(0); acc(13'h0F0F, 1'b0, s);
    acc(13'h0F0F, 1'b0, s);
    chk("R10 repeat key alone", s, 2'b00);
    acc(13'h10F0, 1'b0, s); acc(13'h0F0E, 1'b0, s);
    chk("R10 partial tail", s, 2'b00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_store; t_recall; t_write_abort; t_wrong;
    t_restart; t_gaps; t_inhibit; t_busy; t_after;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule